// File: doc/BRIEF.md
# Four-Stage Pipeline Writeback and Operand Bypass

This block sits at the back end of a four-stage RISC-V integer pipeline with fetch, execute, memory and writeback stages. It holds the memory-to-writeback stage register. That register captures every candidate writeback value: the ALU result, the load data, the return address (PC+4) and the CSR read value. A four-way select then produces the value that is written to the register file. The block drives the register-file write port directly.

The same block resolves read-after-write hazards for the two source operands of the instruction in execute. Each operand can take its value from two places. The first is the instruction in the memory stage, as held in the execute/memory register. The second is the instruction in the writeback stage, as held in the stage register inside this block. Each forwarded value is the one that the producing instruction's own writeback select picks.

The memory stage cannot forward a load result or a CSR value, because those values are not final until the stage register captures them. When a source operand matches such an instruction, the block raises a stall request for the hazard unit to act on. Data moves forward every clock with no back-pressure inside the block. Holding the pipeline is the job of the stage that consumes the stall request.

Top module: `wb_fwd_stage`

## Requirements
- R1: While reset is asserted and after it is released, the register-file write enable is low until a valid instruction has been captured. With no valid memory-stage instruction, the stall request is low.
- R2: One clock after an instruction is presented with its write enable set and flush low, the write port shows its destination register. The port's write enable is then high exactly when that destination is nonzero.
- R3: The write data is the captured source chosen by the 2-bit select code. The codes are 0 for the ALU result, 1 for load data, 2 for PC+4 and 3 for CSR data. PC+4 is computed from the memory-stage PC modulo 2^XLEN.
- R4: When flush is high at a clock edge, the write enable is low in the following cycle, whatever the incoming write enable was.
- R5: A source operand that names register 0 is delivered as zero. This holds whatever the register-file read value and whatever instructions are in flight.
- R6: When no forwardable memory-stage match exists, the writeback stage can supply the operand. This happens when that stage holds a valid write to the same nonzero register. The delivered value is then the current write data.
- R7: A memory-stage instruction with its write enable set and a destination equal to the nonzero source supplies the operand when its select code is 0 or 2. It supplies the ALU result or PC+4 respectively. This takes priority over the writeback stage.
- R8: A memory-stage match whose select code is 1 or 3 raises the stall request. The operand then falls back to the writeback-stage value or the register-file value.
- R9: With no match in either later stage, the operand equals the register-file read value.
- R10: A memory-stage instruction with its write enable clear, or with destination 0, neither forwards nor raises the stall request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Drops the instruction entering the writeback stage |
| em_alu | input | XLEN | ALU result held in the execute/memory register |
| em_pc | input | XLEN | PC of the memory-stage instruction |
| em_rd | input | log2(NREG) | Destination register of the memory-stage instruction |
| em_wbsel | input | 2 | Writeback select of the memory-stage instruction |
| em_wen | input | 1 | Writeback enable of the memory-stage instruction |
| mem_rdata | input | XLEN | Data returned by the data memory |
| csr_rdata | input | XLEN | Read value from the CSR unit |
| ex_rs1 | input | log2(NREG) | First source register of the execute-stage instruction |
| ex_rs2 | input | log2(NREG) | Second source register of the execute-stage instruction |
| rf_rs1_data | input | XLEN | Register-file read value for the first source |
| rf_rs2_data | input | XLEN | Register-file read value for the second source |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | log2(NREG) | Register-file write address |
| rf_wdata | output | XLEN | Register-file write data |
| fwd_rs1 | output | XLEN | Resolved first operand for execute |
| fwd_rs2 | output | XLEN | Resolved second operand for execute |
| stall_req | output | 1 | A source matches a memory-stage load or CSR read |

## Verification
The bench builds the block with XLEN=8 and NREG=8. This configuration is small enough to enumerate every destination, select code, enable and flush value that can enter the stage register. For each captured instruction, the bench then sweeps every memory-stage destination, select code and enable against every source register. This brings every priority case within reach: register 0, both stages matching, a non-forwardable match falling back to the older stage, and no match at all. It also exercises PC+4 wrapping within the narrow data width.

// File: rtl/wb_fwd_pkg.sv
`timescale 1ns/10ps
package wb_fwd_pkg;
  typedef enum logic [1:0] {
    WB_ALU  = 2'd0,
    WB_LOAD = 2'd1,
    WB_PC4  = 2'd2,
    WB_CSR  = 2'd3
  } wb_sel_e;

  function automatic logic sel_forwardable(input logic [1:0] sel);
    return (wb_sel_e'(sel) == WB_ALU) || (wb_sel_e'(sel) == WB_PC4);
  endfunction
endpackage

// File: rtl/wb_stage_reg.sv
`timescale 1ns/10ps
module wb_stage_reg #(
  parameter int XLEN = 32,
  parameter int AW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic [XLEN-1:0] in_alu,
  input  logic [XLEN-1:0] in_pc4,
  input  logic [XLEN-1:0] in_load,
  input  logic [XLEN-1:0] in_csr,
  input  logic [AW-1:0]   in_rd,
  input  logic [1:0]      in_sel,
  input  logic            in_wen,
  output logic [XLEN-1:0] q_alu,
  output logic [XLEN-1:0] q_pc4,
  output logic [XLEN-1:0] q_load,
  output logic [XLEN-1:0] q_csr,
  output logic [AW-1:0]   q_rd,
  output logic [1:0]      q_sel,
  output logic            q_wen
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_alu  <= '0;
      q_pc4  <= '0;
      q_load <= '0;
      q_csr  <= '0;
      q_rd   <= '0;
      q_sel  <= '0;
      q_wen  <= 1'b0;
    end else begin
      q_alu  <= in_alu;
      q_pc4  <= in_pc4;
      q_load <= in_load;
      q_csr  <= in_csr;
      q_rd   <= in_rd;
      q_sel  <= in_sel;
      q_wen  <= in_wen && !flush;
    end
  end

  // R4
  flush_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !q_wen);
endmodule

// File: rtl/wb_value_mux.sv
`timescale 1ns/10ps
module wb_value_mux
  import wb_fwd_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [1:0]      sel,
  input  logic [XLEN-1:0] alu,
  input  logic [XLEN-1:0] load,
  input  logic [XLEN-1:0] pc4,
  input  logic [XLEN-1:0] csr,
  output logic [XLEN-1:0] y
);
  always_comb begin
    unique case (wb_sel_e'(sel))
      WB_ALU:  y = alu;
      WB_LOAD: y = load;
      WB_PC4:  y = pc4;
      default: y = csr;
    endcase
  end
endmodule

// File: rtl/wb_operand_fwd.sv
`timescale 1ns/10ps
module wb_operand_fwd #(
  parameter int XLEN = 32,
  parameter int AW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   rs,
  input  logic [XLEN-1:0] rf_data,
  input  logic            mem_wen,
  input  logic [AW-1:0]   mem_rd,
  input  logic [XLEN-1:0] mem_val,
  input  logic            mem_ok,
  input  logic            wb_wen,
  input  logic [AW-1:0]   wb_rd,
  input  logic [XLEN-1:0] wb_val,
  output logic [XLEN-1:0] opnd,
  output logic            hazard
);
  logic rs_zero, mem_match, wb_match;

  assign rs_zero   = (rs == '0);
  assign mem_match = mem_wen && (mem_rd == rs) && !rs_zero;
  assign wb_match  = wb_wen && (wb_rd == rs) && !rs_zero;
  assign hazard    = mem_match && !mem_ok;

  always_comb begin
    if (rs_zero)                  opnd = '0;
    else if (mem_match && mem_ok) opnd = mem_val;
    else if (wb_match)            opnd = wb_val;
    else                          opnd = rf_data;
  end

  // R5
  zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs == '0) |-> (opnd == '0));
  // R7
  mem_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wen && mem_ok && mem_rd == rs && rs != '0) |-> (opnd == mem_val));
  // R8
  stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hazard |-> (mem_wen && !mem_ok && mem_rd != '0));
endmodule

// File: rtl/wb_fwd_stage.sv
`timescale 1ns/10ps
module wb_fwd_stage
  import wb_fwd_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG),
  localparam int NOP = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic [XLEN-1:0] em_alu,
  input  logic [XLEN-1:0] em_pc,
  input  logic [AW-1:0]   em_rd,
  input  logic [1:0]      em_wbsel,
  input  logic            em_wen,
  input  logic [XLEN-1:0] mem_rdata,
  input  logic [XLEN-1:0] csr_rdata,
  input  logic [AW-1:0]   ex_rs1,
  input  logic [AW-1:0]   ex_rs2,
  input  logic [XLEN-1:0] rf_rs1_data,
  input  logic [XLEN-1:0] rf_rs2_data,
  output logic            rf_we,
  output logic [AW-1:0]   rf_waddr,
  output logic [XLEN-1:0] rf_wdata,
  output logic [XLEN-1:0] fwd_rs1,
  output logic [XLEN-1:0] fwd_rs2,
  output logic            stall_req
);
  logic [XLEN-1:0] em_pc4, mem_val;
  logic            mem_ok;
  logic [XLEN-1:0] mw_alu, mw_pc4, mw_load, mw_csr;
  logic [AW-1:0]   mw_rd;
  logic [1:0]      mw_sel;
  logic            mw_wen;

  assign em_pc4  = em_pc + XLEN'(4);
  assign mem_ok  = sel_forwardable(em_wbsel);
  assign mem_val = (wb_sel_e'(em_wbsel) == WB_PC4) ? em_pc4 : em_alu;

  wb_stage_reg #(.XLEN(XLEN), .AW(AW)) u_mw (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_alu(em_alu), .in_pc4(em_pc4), .in_load(mem_rdata), .in_csr(csr_rdata),
    .in_rd(em_rd), .in_sel(em_wbsel), .in_wen(em_wen),
    .q_alu(mw_alu), .q_pc4(mw_pc4), .q_load(mw_load), .q_csr(mw_csr),
    .q_rd(mw_rd), .q_sel(mw_sel), .q_wen(mw_wen)
  );

  wb_value_mux #(.XLEN(XLEN)) u_wbmux (
    .sel(mw_sel), .alu(mw_alu), .load(mw_load), .pc4(mw_pc4), .csr(mw_csr),
    .y(rf_wdata)
  );

  assign rf_we    = mw_wen && (mw_rd != '0);
  assign rf_waddr = mw_rd;

  logic [NOP-1:0][AW-1:0]   src_rs;
  logic [NOP-1:0][XLEN-1:0] src_rf, src_out;
  logic [NOP-1:0]           src_haz;

  assign src_rs[0] = ex_rs1;
  assign src_rs[1] = ex_rs2;
  assign src_rf[0] = rf_rs1_data;
  assign src_rf[1] = rf_rs2_data;

  for (genvar i = 0; i < NOP; i++) begin : g_src
    wb_operand_fwd #(.XLEN(XLEN), .AW(AW)) u_fwd (
      .clk(clk), .rst_n(rst_n),
      .rs(src_rs[i]), .rf_data(src_rf[i]),
      .mem_wen(em_wen), .mem_rd(em_rd), .mem_val(mem_val), .mem_ok(mem_ok),
      .wb_wen(mw_wen), .wb_rd(mw_rd), .wb_val(rf_wdata),
      .opnd(src_out[i]), .hazard(src_haz[i])
    );
  end

  assign fwd_rs1   = src_out[0];
  assign fwd_rs2   = src_out[1];
  assign stall_req = |src_haz;

  // R2
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (em_wen && !flush && em_rd != '0) |=> (rf_we && rf_waddr == $past(em_rd)));
  // R3
  load_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (em_wbsel == 2'd1) |=> (rf_wdata == $past(mem_rdata)));
  // R10
  idle_nostall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!em_wen || em_rd == '0) |-> !stall_req);
endmodule

// File: tb/wb_fwd_stage_bench.sv
`timescale 1ns/10ps
module wb_fwd_stage_bench;
  localparam real CLK_PERIOD = 20.0;
  localparam int  XLEN = 8;
  localparam int  NREG = 8;
  localparam int  AW   = 3;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic [XLEN-1:0] em_alu = '0, em_pc = '0, mem_rdata = '0, csr_rdata = '0;
  logic [AW-1:0]   em_rd = '0, ex_rs1 = '0, ex_rs2 = '0;
  logic [1:0]      em_wbsel = '0;
  logic            em_wen = 1'b0;
  logic [XLEN-1:0] rf_rs1_data = '0, rf_rs2_data = '0;
  logic            rf_we, stall_req;
  logic [AW-1:0]   rf_waddr;
  logic [XLEN-1:0] rf_wdata, fwd_rs1, fwd_rs2;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model of the captured writeback-stage instruction
  logic [AW-1:0]   m_rd;
  logic            m_wen;
  logic [XLEN-1:0] m_val;

  always #(CLK_PERIOD/2) clk = ~clk;

  wb_fwd_stage #(.XLEN(XLEN), .NREG(NREG)) u_wb_fwd_stage (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .em_alu(em_alu), .em_pc(em_pc), .em_rd(em_rd), .em_wbsel(em_wbsel),
    .em_wen(em_wen), .mem_rdata(mem_rdata), .csr_rdata(csr_rdata),
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
    .rf_rs1_data(rf_rs1_data), .rf_rs2_data(rf_rs2_data),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .fwd_rs1(fwd_rs1), .fwd_rs2(fwd_rs2), .stall_req(stall_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [XLEN-1:0] exp_opnd(input logic [AW-1:0] rs, input logic [XLEN-1:0] rfv);
    if (rs == 0) return '0;
    if (em_wen && em_rd == rs && em_wbsel == 2'd0) return em_alu;
    if (em_wen && em_rd == rs && em_wbsel == 2'd2) return XLEN'(em_pc + 4);
    if (m_wen && m_rd == rs) return m_val;
    return rfv;
  endfunction

  function automatic string opnd_tag(input logic [AW-1:0] rs);
    if (rs == 0) return "R5";
    if (em_rd == rs && em_wen && (em_wbsel == 2'd0 || em_wbsel == 2'd2)) return "R7";
    if (em_rd == rs && em_wen) return "R8";
    if (em_rd == rs) return "R10";
    if (m_wen && m_rd == rs) return "R6";
    return "R9";
  endfunction

  function automatic logic exp_stall();
    return em_wen && em_rd != 0 && (em_wbsel == 2'd1 || em_wbsel == 2'd3) &&
           (ex_rs1 == em_rd || ex_rs2 == em_rd);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int k = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: during reset
    check("R1 we in reset", rf_we, 0);
    rst_n = 1'b1;
    ex_rs1 = 3; rf_rs1_data = 8'h5a;
    @(posedge clk); #1;
    check("R1 we after reset", rf_we, 0);
    check("R1 stall after reset", stall_req, 0);
    check("R1 operand passthrough", fwd_rs1, 8'h5a);

    for (int rd = 0; rd < NREG; rd++)
      for (int sel = 0; sel < 4; sel++)
        for (int wen = 0; wen < 2; wen++)
          for (int fl = 0; fl < 2; fl++) begin
            k++;
            em_rd = AW'(rd); em_wbsel = 2'(sel); em_wen = wen[0]; flush = fl[0];
            em_alu = XLEN'(k*37 + 5);
            em_pc  = XLEN'(k*11 + 250);
            mem_rdata = XLEN'(k*53 + 9);
            csr_rdata = XLEN'(k*71 + 3);
            case (sel)
              0: m_val = em_alu;
              1: m_val = mem_rdata;
              2: m_val = XLEN'(em_pc + 4);
              default: m_val = csr_rdata;
            endcase
            m_rd = AW'(rd); m_wen = wen[0] && !fl[0];
            @(posedge clk); #1;
            flush = 1'b0;
            check("R2 waddr", rf_waddr, m_rd);
            check(fl ? "R4 flushed we" : "R2 we", rf_we, m_wen && m_rd != 0);
            check("R3 wdata", rf_wdata, m_val);
            // sweep the memory stage and the sources against this writeback state
            for (int erd = 0; erd < NREG; erd++)
              for (int es = 0; es < 4; es++)
                for (int ew = 0; ew < 2; ew++)
                  for (int rs = 0; rs < NREG; rs++) begin
                    em_rd = AW'(erd); em_wbsel = 2'(es); em_wen = ew[0];
                    em_alu = XLEN'(erd*29 + es*7 + 1);
                    em_pc  = XLEN'(erd*31 + 252);
                    ex_rs1 = AW'(rs); ex_rs2 = AW'((rs + 3) % NREG);
                    rf_rs1_data = XLEN'(rs*13 + 100);
                    rf_rs2_data = XLEN'(rs*17 + 40);
                    #0.01;
                    check(opnd_tag(ex_rs1), fwd_rs1, exp_opnd(ex_rs1, rf_rs1_data));
                    check(opnd_tag(ex_rs2), fwd_rs2, exp_opnd(ex_rs2, rf_rs2_data));
                    check(exp_stall() ? "R8 stall" : "R10 no stall", stall_req, exp_stall());
                  end
          end

    // R4: flush at an edge with a valid incoming write
    em_rd = 5; em_wen = 1; em_wbsel = 0; flush = 1;
    @(posedge clk); #1;
    flush = 0;
    check("R4 flush final", rf_we, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule